// File: doc/BRIEF.md
# Maskable Status Interrupt Unit with Selectable Polarity

This unit gathers status events from a receiver front end and turns them into a single interrupt request. The events are:

- a measurement counter finishing,
- a tuning control loop leaving its range,
- any change of a 7-bit thermometer-coded signal-strength level,
- a flip of the mono/stereo indication,
- a received-data-available level.

Each edge-type event has its own enable bit in a mask register. An enabled event is latched into a flag. The flags are presented in a fixed-layout identify byte.

Flags are not cleared through a dedicated register. They clear as a side effect of the host reading one of two status registers. The serial port reports those reads to this unit as one-cycle strobes.

The combined request can be given either polarity. After the host writes (any value) to an interrupt-routing register, the request takes over the shared serial data line. Until then, that line is driven by the serial port's own output and output-enable.

Top module: `irq_event_unit`

## Requirements
- R1: After reset the identify byte reads 8'h80, the mask is all zero (active-high request, no event enabled), the request output is 0, and the data line follows the serial port's data and enable.
- R2: Mask bit 0 enables counter-done, bit 1 enables signal-strength change, bit 2 enables out-of-range, and bit 6 enables mono/stereo change. An event whose mask bit is 0 leaves no flag.
- R3: Identify byte layout:
  - bit 7 always reads 1;
  - bit 6 is the live data-available level;
  - bit 5 is the counter-done flag;
  - bit 3 is the out-of-range flag;
  - bit 0 is the shared signal-strength / mono-stereo change flag;
  - bits 4, 2 and 1 read 0.
- R4: An enabled event is visible in the identify byte one clock after it is sampled, and the flag stays set until its clearing read.
- R5: A control-status read strobe clears identify bits 5 and 3 and leaves bit 0 unchanged.
- R6: A station-status read strobe clears identify bit 0 and leaves bits 5 and 3 unchanged.
- R7: When an enabled event and its clearing read fall in the same cycle, the flag ends up set.
- R8: Any difference between the 7-bit strength code and its value one cycle earlier is a strength-change event. No event is produced on the first clock after reset.
- R9: A change of the stereo bit in either direction is a mono/stereo change event.
- R10: Mask bit 3 selects the polarity. With 0 the request is high while any flag or data-available is set. With 1 it is low in that case and high otherwise.
- R11: A write to the interrupt-routing register makes the unit drive the data line permanently with the request (output enable 1) until reset. Before that write the line passes the serial port's data and enable unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | 8 | Mask write data |
| route_wr | input | 1 | Interrupt-routing register write strobe |
| ctl_rd | input | 1 | Control-status register read strobe |
| stn_rd | input | 1 | Station-status register read strobe |
| cnt_done | input | 1 | Counter finished event |
| loop_oor | input | 1 | Control loop out of range event |
| fs_code | input | 7 | Thermometer signal-strength code |
| stereo | input | 1 | Stereo indication |
| dav | input | 1 | Data-available level |
| sp_dout | input | 1 | Serial port data toward the line |
| sp_oe | input | 1 | Serial port output enable |
| irq_id | output | 8 | Identify byte |
| irq_req | output | 1 | Polarity-adjusted request |
| line_out | output | 1 | Value driven on the data line |
| line_oe | output | 1 | Data line output enable |

## Verification
Flag results are registered. An event, mask write, clearing read or routing write sampled at a rising edge shows at the outputs right after that edge. The data-available level and the serial-port pass-through are combinational and show within the same cycle. The bench drives inputs just after the falling edge. It updates a behavioural model at each rising edge and compares all outputs at the following falling edge, so registered and combinational results are both checked one half-period after they settle. Directed checks sit at exactly those falling edges and name the requirement they cover.

// File: rtl/irq_event_pkg.sv
package irq_event_pkg;
  localparam int FS_W   = 7;
  localparam int BYTE_W = 8;

  // mask register bit positions (decoded by the host driver)
  localparam int MB_CNT = 0;
  localparam int MB_FS  = 1;
  localparam int MB_OOR = 2;
  localparam int MB_POL = 3;
  localparam int MB_MS  = 6;

  // identify byte bit positions
  localparam int IB_FSMS = 0;
  localparam int IB_OOR  = 3;
  localparam int IB_CNT  = 5;
  localparam int IB_DAV  = 6;
  localparam int IB_ONE  = 7;

  function automatic logic code_moved(input logic [FS_W-1:0] prev,
                                      input logic [FS_W-1:0] cur);
    return |(prev ^ cur);
  endfunction

  function automatic logic apply_pol(input logic raw, input logic act_low);
    return act_low ? ~raw : raw;
  endfunction
endpackage

// File: rtl/evt_change_det.sv
module evt_change_det
  import irq_event_pkg::*;
#(
  parameter int CW = FS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] code,
  input  logic          st,
  output logic          code_chg,
  output logic          st_chg
);
  logic [CW-1:0] prev_code;
  logic          prev_st;
  logic          prev_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_code <= '0;
      prev_st   <= 1'b0;
      prev_vld  <= 1'b0;
    end else begin
      prev_code <= code;
      prev_st   <= st;
      prev_vld  <= 1'b1;
    end
  end

  assign code_chg = prev_vld && |(prev_code ^ code);
  assign st_chg   = prev_vld && (prev_st != st);

  // R8: an unchanged code yields no event
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (code == $past(code)) |-> !code_chg);
  // R9: a flipped stereo bit after the first cycle yields an event
  a_r9_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_vld && st != $past(st)) |-> st_chg);
endmodule

// File: rtl/flag_bank.sv
module flag_bank (
  input  logic clk,
  input  logic rst_n,
  input  logic set_cnt,
  input  logic set_oor,
  input  logic set_fsms,
  input  logic clr_ctl,
  input  logic clr_stn,
  output logic cnt_f,
  output logic oor_f,
  output logic fsms_f
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_f  <= 1'b0;
      oor_f  <= 1'b0;
      fsms_f <= 1'b0;
    end else begin
      cnt_f  <= set_cnt  | (cnt_f  & ~clr_ctl);
      oor_f  <= set_oor  | (oor_f  & ~clr_ctl);
      fsms_f <= set_fsms | (fsms_f & ~clr_stn);
    end
  end

  // R4: a flag holds until its clearing read
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_f && !clr_ctl) |=> cnt_f);
  // R5: control-status read clears counter and out-of-range flags
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ctl && !set_cnt && !set_oor) |=> (!cnt_f && !oor_f));
  // R6: station-status read clears the change flag
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stn && !set_fsms) |=> !fsms_f);
  // R7: setting wins over clearing
  a_r7_setwins: assert property (@(posedge clk) disable iff (!rst_n)
    set_fsms |=> fsms_f);
endmodule

// File: rtl/irq_out_drv.sv
module irq_out_drv
  import irq_event_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic raw_req,
  input  logic act_low,
  input  logic route_wr,
  input  logic sp_dout,
  input  logic sp_oe,
  output logic irq_req,
  output logic line_out,
  output logic line_oe
);
  logic routed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) routed <= 1'b0;
    else if (route_wr) routed <= 1'b1;
  end

  assign irq_req  = apply_pol(raw_req, act_low);
  assign line_out = routed ? irq_req : sp_dout;
  assign line_oe  = routed ? 1'b1 : sp_oe;

  // R11: routing is sticky
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    routed |=> routed);
  // R11: a routed line carries the request
  a_r11_drive: assert property (@(posedge clk) disable iff (!rst_n)
    routed |-> (line_oe && line_out == irq_req));
  // R10: an idle request sits at the inactive level
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_req |-> (irq_req == act_low));
endmodule

// File: rtl/irq_event_unit.sv
module irq_event_unit
  import irq_event_pkg::*;
#(
  parameter int CODE_W = FS_W,
  parameter int REG_W  = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_wr,
  input  logic [REG_W-1:0]  mask_wdata,
  input  logic              route_wr,
  input  logic              ctl_rd,
  input  logic              stn_rd,
  input  logic              cnt_done,
  input  logic              loop_oor,
  input  logic [CODE_W-1:0] fs_code,
  input  logic              stereo,
  input  logic              dav,
  input  logic              sp_dout,
  input  logic              sp_oe,
  output logic [REG_W-1:0]  irq_id,
  output logic              irq_req,
  output logic              line_out,
  output logic              line_oe
);
  logic en_cnt, en_fs, en_oor, en_ms, act_low;
  logic fs_chg, ms_chg;
  logic set_cnt, set_oor, set_fsms;
  logic cnt_f, oor_f, fsms_f;
  logic raw_req;
  logic unused_wbits;

  assign unused_wbits = ^{mask_wdata[REG_W-1], mask_wdata[5:4]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_cnt  <= 1'b0;
      en_fs   <= 1'b0;
      en_oor  <= 1'b0;
      en_ms   <= 1'b0;
      act_low <= 1'b0;
    end else if (mask_wr) begin
      en_cnt  <= mask_wdata[MB_CNT];
      en_fs   <= mask_wdata[MB_FS];
      en_oor  <= mask_wdata[MB_OOR];
      en_ms   <= mask_wdata[MB_MS];
      act_low <= mask_wdata[MB_POL];
    end
  end

  evt_change_det #(.CW(CODE_W)) u_det (
    .clk(clk), .rst_n(rst_n), .code(fs_code), .st(stereo),
    .code_chg(fs_chg), .st_chg(ms_chg)
  );

  assign set_cnt  = cnt_done & en_cnt;
  assign set_oor  = loop_oor & en_oor;
  assign set_fsms = (fs_chg & en_fs) | (ms_chg & en_ms);

  flag_bank u_flags (
    .clk(clk), .rst_n(rst_n),
    .set_cnt(set_cnt), .set_oor(set_oor), .set_fsms(set_fsms),
    .clr_ctl(ctl_rd), .clr_stn(stn_rd),
    .cnt_f(cnt_f), .oor_f(oor_f), .fsms_f(fsms_f)
  );

  always_comb begin
    irq_id          = '0;
    irq_id[IB_ONE]  = 1'b1;
    irq_id[IB_DAV]  = dav;
    irq_id[IB_CNT]  = cnt_f;
    irq_id[IB_OOR]  = oor_f;
    irq_id[IB_FSMS] = fsms_f;
  end

  assign raw_req = cnt_f | oor_f | fsms_f | dav;

  irq_out_drv u_out (
    .clk(clk), .rst_n(rst_n), .raw_req(raw_req), .act_low(act_low),
    .route_wr(route_wr), .sp_dout(sp_dout), .sp_oe(sp_oe),
    .irq_req(irq_req), .line_out(line_out), .line_oe(line_oe)
  );

  // R2: a masked-off counter event leaves no flag
  a_r2_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_id[IB_CNT] && !(cnt_done && en_cnt)) |=> !irq_id[IB_CNT]);
  // R3: reserved identify bits
  a_r3_layout: assert property (@(posedge clk) disable iff (!rst_n)
    irq_id[IB_ONE] && !irq_id[4] && !irq_id[2] && !irq_id[1]);
endmodule

// File: tb/sim_irq_event_unit.sv
`timescale 1ns/100ps
module sim_irq_event_unit;
  logic clk = 0, rst_n = 0;
  logic mask_wr = 0, route_wr = 0, ctl_rd = 0, stn_rd = 0;
  logic [7:0] mask_wdata = 0;
  logic cnt_done = 0, loop_oor = 0, stereo = 0, dav = 0;
  logic [6:0] fs_code = 7'h7F;
  logic sp_dout = 0, sp_oe = 0;
  logic [7:0] irq_id;
  logic irq_req, line_out, line_oe;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  irq_event_unit u0 (.*);

  always #2.5 clk = ~clk;

  // behavioural reference state
  int m_mask = 0, m_route = 0, m_cnt = 0, m_oor = 0, m_fsms = 0;
  int m_pfs = 0, m_pst = 0, m_pv = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = 0; m_route = 0; m_cnt = 0; m_oor = 0; m_fsms = 0;
      m_pfs = 0; m_pst = 0; m_pv = 0;
    end else begin
      int fch, mch;
      fch = (m_pv != 0) && (int'(fs_code) != m_pfs);
      mch = (m_pv != 0) && (int'(stereo) != m_pst);
      m_cnt  = ((cnt_done && m_mask[0]) || (m_cnt != 0 && !ctl_rd)) ? 1 : 0;
      m_oor  = ((loop_oor && m_mask[2]) || (m_oor != 0 && !ctl_rd)) ? 1 : 0;
      m_fsms = ((fch != 0 && m_mask[1]) || (mch != 0 && m_mask[6]) ||
                (m_fsms != 0 && !stn_rd)) ? 1 : 0;
      if (mask_wr) m_mask = int'(mask_wdata);
      if (route_wr) m_route = 1;
      m_pfs = int'(fs_code); m_pst = int'(stereo); m_pv = 1;
    end
  end

  function automatic int exp_id();
    return 128 + (dav ? 64 : 0) + 32*m_cnt + 8*m_oor + m_fsms;
  endfunction
  function automatic int exp_req();
    int raw;
    raw = (m_cnt != 0 || m_oor != 0 || m_fsms != 0 || dav) ? 1 : 0;
    return m_mask[3] ? 1 - raw : raw;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    chk("R3 model id", int'(irq_id), exp_id());
    chk("R10 model req", int'(irq_req), exp_req());
    chk("R11 model line", int'(line_out), m_route != 0 ? exp_req() : int'(sp_dout));
    chk("R11 model oe", int'(line_oe), m_route != 0 ? 1 : int'(sp_oe));
  end

  // advance one clock; returns just after the following falling edge
  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask
  task automatic drive(); #0.5; endtask

  task automatic pulse_mask(input logic [7:0] v);
    drive(); mask_wr = 1; mask_wdata = v; tick(); drive(); mask_wr = 0;
  endtask

  initial begin
    #200000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #12 rst_n = 1;
    @(negedge clk);
    tick();
    // R1 reset state; R8 no event on first clock (code 7F differs from cleared history)
    chk("R1 id", int'(irq_id), 'h80);
    chk("R1 req", int'(irq_req), 0);
    chk("R8 first cycle", int'(irq_id[0]), 0);
    drive(); sp_dout = 1; sp_oe = 1; tick();
    chk("R1 pass data", int'(line_out), 1);
    chk("R1 pass oe", int'(line_oe), 1);
    // R2 masked counter event
    drive(); sp_oe = 0; cnt_done = 1; tick(); drive(); cnt_done = 0;
    chk("R2 masked", int'(irq_id), 'h80);
    pulse_mask(8'h47);
    drive(); cnt_done = 1; tick(); drive(); cnt_done = 0;
    chk("R4 cnt latched", int'(irq_id), 'hA0);
    tick(); tick();
    chk("R4 cnt held", int'(irq_id), 'hA0);
    drive(); loop_oor = 1; tick(); drive(); loop_oor = 0;
    chk("R3 oor bit3", int'(irq_id), 'hA8);
    drive(); stn_rd = 1; tick(); drive(); stn_rd = 0;
    chk("R6 keeps 5,3", int'(irq_id), 'hA8);
    drive(); ctl_rd = 1; tick(); drive(); ctl_rd = 0;
    chk("R5 clears 5,3", int'(irq_id), 'h80);
    drive(); fs_code = 7'h3F; tick();
    chk("R8 code change", int'(irq_id), 'h81);
    drive(); ctl_rd = 1; tick(); drive(); ctl_rd = 0;
    chk("R5 keeps 0", int'(irq_id), 'h81);
    drive(); stn_rd = 1; tick(); drive(); stn_rd = 0;
    chk("R6 clears 0", int'(irq_id), 'h80);
    drive(); fs_code = 7'h00; tick(); drive(); stn_rd = 1; tick(); drive(); stn_rd = 0;
    drive(); stereo = 1; tick();
    chk("R9 to stereo", int'(irq_id), 'h81);
    drive(); stn_rd = 1; tick(); drive(); stn_rd = 0; stereo = 0; tick();
    chk("R9 to mono", int'(irq_id), 'h81);
    drive(); stn_rd = 1; tick(); drive(); stn_rd = 0;
    pulse_mask(8'h45);
    drive(); fs_code = 7'h01; tick();
    chk("R2 fs masked", int'(irq_id), 'h80);
    drive(); stereo = 1; stn_rd = 1; tick(); drive(); stn_rd = 0;
    chk("R7 set wins", int'(irq_id), 'h81);
    drive(); stn_rd = 1; tick(); drive(); stn_rd = 0; dav = 1; tick();
    chk("R3 dav live", int'(irq_id), 'hC0);
    chk("R10 high active", int'(irq_req), 1);
    drive(); dav = 0;
    pulse_mask(8'h4D);
    chk("R10 low idle", int'(irq_req), 1);
    drive(); dav = 1; tick();
    chk("R10 low active", int'(irq_req), 0);
    drive(); sp_dout = 1; sp_oe = 0; route_wr = 1; tick(); drive(); route_wr = 0;
    chk("R11 routed data", int'(line_out), 0);
    chk("R11 routed oe", int'(line_oe), 1);
    drive(); dav = 0; tick(); tick();
    chk("R11 sticky", int'(line_out), 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule